// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with Reload Divider

This block sends and receives asynchronous serial frames at the same time. Each frame has one low start bit, then 7, 8 or 9 data bits sent least significant bit first, then one high stop bit. There is no parity bit. The block clock runs at six ticks per instruction cycle. The bit time comes from an 8-bit reload value and a speed-select input, so one bit lasts 8(n+1) ticks in fast mode or 32(n+1) ticks in slow mode.

On the transmit side, software writes a parallel word with a one-cycle start strobe and watches a busy flag. A strobe given in the last tick of a stop bit starts the next frame with no idle time in between. On the receive side, the block detects the falling edge of a start bit and checks that the line is still low at the middle of that bit. It then samples every data bit and the stop bit at mid-bit. The received word is held with a ready flag until it is read. A low stop bit sets a framing-error flag, and a frame that completes before the previous word was read sets an overrun flag. Transmit completion and receive completion each set their own sticky interrupt flag.

Top module: `uart_duplex`

## Requirements
- R1: After reset, tx_o is high and tx_busy_o, tx_irq_o, rx_ready_o, rx_irq_o, rx_frame_err_o and rx_overrun_o are all low.
- R2: One bit lasts (reload_i+1)*8 clock cycles when fast_i=1 and (reload_i+1)*32 clock cycles when fast_i=0. This applies to the transmitted start bit and to every other bit.
- R3: len_i selects the data length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 or 2'b11 gives 9 bits. Data goes out LSB first from tx_data_i[0]. Received data appears right-aligned on rx_data_o, and its unused upper bits read as zero.
- R4: A tx_start_i accepted while tx_busy_o is low drives tx_o low and raises tx_busy_o in the next cycle. A strobe given while tx_busy_o is high is ignored.
- R5: tx_busy_o falls in the last tick of the stop bit. A strobe given in that tick starts the next start bit right away, so accepted strobes in a continuous stream are exactly (len+2) bit times apart.
- R6: tx_irq_o is set at the end of each transmitted frame. It stays set until tx_irq_clr_i is asserted.
- R7: A low pulse on rx_i that has ended before the middle of a start bit is rejected. It produces no data, no ready flag and no interrupt.
- R8: Each received frame loads rx_data_o and sets rx_ready_o and rx_irq_o. rx_read_i clears rx_ready_o, and rx_irq_clr_i clears rx_irq_o.
- R9: rx_frame_err_o shows whether the stop bit of the last completed frame was sampled low.
- R10: If a frame completes while rx_ready_o is still set and is not being read, rx_overrun_o is set and the new data replaces the old. rx_read_i clears rx_overrun_o.
- R11: The receiver accepts frames that follow each other with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock, six ticks per instruction cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | 8 | Divider reload value n |
| fast_i | input | 1 | 1 selects 8 ticks per (n+1), 0 selects 32 ticks per (n+1) |
| len_i | input | 2 | Data length select |
| tx_data_i | input | 9 | Word to transmit |
| tx_start_i | input | 1 | Transmit start strobe |
| tx_busy_o | output | 1 | Transmitter cannot take a strobe |
| tx_o | output | 1 | Serial output line |
| tx_irq_o | output | 1 | Transmit-done interrupt flag |
| tx_irq_clr_i | input | 1 | Clears tx_irq_o |
| rx_i | input | 1 | Serial input line, asynchronous |
| rx_data_o | output | 9 | Last received word |
| rx_ready_o | output | 1 | Received word not yet read |
| rx_read_i | input | 1 | Acknowledges the received word |
| rx_irq_o | output | 1 | Receive-done interrupt flag |
| rx_irq_clr_i | input | 1 | Clears rx_irq_o |
| rx_frame_err_o | output | 1 | Stop bit of the last frame was low |
| rx_overrun_o | output | 1 | A word was overwritten before it was read |

## Verification
Two conditions are the hardest to create from the ports: a gapless transmit stream, and overrun. For a gapless stream, the driver must present the next strobe in the one tick where busy has dropped but the stop bit is still on the line. The bench samples busy on the falling edge and strobes in that same cycle, then checks that strobe-to-strobe spacing is exactly ten bit times. To force an overrun, the bench turns off the scoreboard's reading monitor and drives two back-to-back frames straight onto rx_i. It then checks that the second word has replaced the first. A runt start pulse and a frame with a low stop bit are also driven directly on rx_i, not through the loopback.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} uart_state_e;
endpackage

// File: rtl/uart_bit_period.sv
module uart_bit_period #(
  parameter int RELOAD_W   = 8,
  parameter int FAST_SHIFT = 3,
  parameter int SLOW_SHIFT = 5,
  parameter int PER_W      = RELOAD_W + 1 + SLOW_SHIFT
) (
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                fast_i,
  output logic [PER_W-1:0]    period_o
);
  logic [PER_W-1:0] base;
  assign base     = PER_W'(reload_i) + PER_W'(1);
  assign period_o = fast_i ? (base << FAST_SHIFT) : (base << SLOW_SHIFT);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int PER_W  = 14,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PER_W-1:0]  period_i,
  input  logic [IDX_W-1:0]  nbits_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              tx_o,
  output logic              irq_o,
  input  logic              irq_clr_i
);
  uart_state_e       state;
  logic [PER_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              last_tick, accept;

  assign last_tick = (cnt == period_i - PER_W'(1));
  // busy drops in the final stop tick so a queued strobe continues gaplessly
  assign busy_o    = (state != ST_IDLE) && !(state == ST_STOP && last_tick);
  assign accept    = start_i && !busy_o;

  always_comb begin
    case (state)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = shreg[0];
      default:  tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else if (accept) begin
      state <= ST_START;
      cnt   <= '0;
      shreg <= data_i;
    end else begin
      case (state)
        ST_START: begin
          if (last_tick) begin
            state   <= ST_DATA;
            cnt     <= '0;
            bit_idx <= '0;
          end else cnt <= cnt + PER_W'(1);
        end
        ST_DATA: begin
          if (last_tick) begin
            cnt   <= '0;
            shreg <= shreg >> 1;
            if (bit_idx == nbits_i - IDX_W'(1)) state <= ST_STOP;
            else bit_idx <= bit_idx + IDX_W'(1);
          end else cnt <= cnt + PER_W'(1);
        end
        ST_STOP: begin
          if (last_tick) state <= ST_IDLE;
          else cnt <= cnt + PER_W'(1);
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else if (state == ST_STOP && last_tick) irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end

  // R4
  tx_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !tx_o));
  // R6
  tx_irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  // R5
  tx_busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (state == ST_STOP));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int PER_W  = 14,
  parameter int IDX_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PER_W-1:0]  period_i,
  input  logic [IDX_W-1:0]  nbits_i,
  input  logic              rx_i,
  input  logic              read_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              irq_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  uart_state_e       state;
  logic [2:0]        sync;
  logic [PER_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              rx_s, fall, last_tick, mid_tick, done;

  assign rx_s      = sync[1];
  assign fall      = sync[2] && !sync[1];
  assign last_tick = (cnt == period_i - PER_W'(1));
  assign mid_tick  = (cnt == (period_i >> 1) - PER_W'(1));
  assign done      = (state == ST_STOP) && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync <= '1;
    else sync <= {sync[1:0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (fall) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: begin
          if (mid_tick) begin
            state   <= rx_s ? ST_IDLE : ST_DATA;  // high at mid-start: glitch
            cnt     <= '0;
            bit_idx <= '0;
          end else cnt <= cnt + PER_W'(1);
        end
        ST_DATA: begin
          if (last_tick) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            if (bit_idx == nbits_i - IDX_W'(1)) state <= ST_STOP;
            else bit_idx <= bit_idx + IDX_W'(1);
          end else cnt <= cnt + PER_W'(1);
        end
        default: begin
          if (last_tick) state <= ST_IDLE;
          else cnt <= cnt + PER_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      ready_o     <= 1'b0;
      irq_o       <= 1'b0;
      frame_err_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      if (done) begin
        data_o      <= shreg >> (DATA_W - int'(nbits_i));
        frame_err_o <= !rx_s;
      end
      if (done) ready_o <= 1'b1;
      else if (read_i) ready_o <= 1'b0;
      if (done) irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (done && ready_o && !read_i) overrun_o <= 1'b1;
      else if (read_i) overrun_o <= 1'b0;
    end
  end

  // R10
  rx_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ready_o);
  // R8
  rx_ready_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(state == ST_STOP));
  // R7
  rx_idle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && sync[2:1] != 2'b10) |=> (state == ST_IDLE));
endmodule

// File: rtl/uart_duplex.sv
module uart_duplex #(
  parameter int RELOAD_W   = 8,
  parameter int DATA_W     = 9,
  parameter int FAST_SHIFT = 3,
  parameter int SLOW_SHIFT = 5,
  localparam int PER_W     = RELOAD_W + 1 + SLOW_SHIFT,
  localparam int IDX_W     = $clog2(DATA_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                fast_i,
  input  logic [1:0]          len_i,
  input  logic [DATA_W-1:0]   tx_data_i,
  input  logic                tx_start_i,
  output logic                tx_busy_o,
  output logic                tx_o,
  output logic                tx_irq_o,
  input  logic                tx_irq_clr_i,
  input  logic                rx_i,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic                rx_ready_o,
  input  logic                rx_read_i,
  output logic                rx_irq_o,
  input  logic                rx_irq_clr_i,
  output logic                rx_frame_err_o,
  output logic                rx_overrun_o
);
  logic [PER_W-1:0] period;
  logic [IDX_W-1:0] nbits;

  always_comb begin
    case (len_i)
      2'b00:   nbits = IDX_W'(DATA_W - 2);
      2'b01:   nbits = IDX_W'(DATA_W - 1);
      default: nbits = IDX_W'(DATA_W);
    endcase
  end

  uart_bit_period #(.RELOAD_W(RELOAD_W), .FAST_SHIFT(FAST_SHIFT),
                    .SLOW_SHIFT(SLOW_SHIFT), .PER_W(PER_W)) u_period (
    .reload_i(reload_i), .fast_i(fast_i), .period_o(period));

  uart_tx #(.DATA_W(DATA_W), .PER_W(PER_W), .IDX_W(IDX_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period), .nbits_i(nbits),
    .data_i(tx_data_i), .start_i(tx_start_i), .busy_o(tx_busy_o),
    .tx_o(tx_o), .irq_o(tx_irq_o), .irq_clr_i(tx_irq_clr_i));

  uart_rx #(.DATA_W(DATA_W), .PER_W(PER_W), .IDX_W(IDX_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period), .nbits_i(nbits),
    .rx_i(rx_i), .read_i(rx_read_i), .irq_clr_i(rx_irq_clr_i),
    .data_o(rx_data_o), .ready_o(rx_ready_o), .irq_o(rx_irq_o),
    .frame_err_o(rx_frame_err_o), .overrun_o(rx_overrun_o));
endmodule

// File: tb/uart_duplex_tb.sv
module uart_duplex_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic [7:0] reload_i = 8'd1;
  logic       fast_i = 1'b1;
  logic [1:0] len_i = 2'b01;
  logic [8:0] tx_data_i = '0;
  logic       tx_start_i = 0, tx_irq_clr_i = 0;
  logic       tx_busy_o, tx_o, tx_irq_o;
  logic       rx_i, rx_ready_o, rx_irq_o, rx_frame_err_o, rx_overrun_o;
  logic [8:0] rx_data_o;
  logic       loop_en = 1, rx_drv = 1;
  logic       mon_en = 1, mon_read = 0, man_read = 0, man_clr = 0;

  assign rx_i = loop_en ? tx_o : rx_drv;

  uart_duplex u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload_i), .fast_i(fast_i),
    .len_i(len_i), .tx_data_i(tx_data_i), .tx_start_i(tx_start_i),
    .tx_busy_o(tx_busy_o), .tx_o(tx_o), .tx_irq_o(tx_irq_o),
    .tx_irq_clr_i(tx_irq_clr_i), .rx_i(rx_i), .rx_data_o(rx_data_o),
    .rx_ready_o(rx_ready_o), .rx_read_i(mon_read | man_read),
    .rx_irq_o(rx_irq_o), .rx_irq_clr_i(mon_read | man_clr),
    .rx_frame_err_o(rx_frame_err_o), .rx_overrun_o(rx_overrun_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, got_n = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R3";
  logic [9:0] exp_q[$];  // {frame_err, data}

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_ticks(int n, bit fast);
    return (n + 1) * (fast ? 8 : 32);
  endfunction

  function automatic int nbits_of(logic [1:0] len);
    return (len == 2'b00) ? 7 : (len == 2'b01) ? 8 : 9;
  endfunction

  function automatic logic [8:0] mask_len(logic [8:0] d, logic [1:0] len);
    return d & ((9'h1 << nbits_of(len)) - 9'h1) | ((len[1]) ? (d & 9'h100) : 9'h0);
  endfunction

  // scoreboard monitor
  initial forever begin
    @(negedge clk_i);
    mon_read = 0;
    if (mon_en && rst_ni && rx_ready_o) begin
      got_n++;
      if (exp_q.size() == 0) chk(0, "R7 unexpected frame", rx_data_o, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(rx_data_o == e[8:0], cur_req, rx_data_o, e[8:0]);
        chk(rx_frame_err_o == e[9], "R9 frame error", rx_frame_err_o, e[9]);
        chk(rx_irq_o == 1'b1, "R8 rx irq", rx_irq_o, 1);
      end
      mon_read = 1;
    end
  end

  task automatic tx_send(logic [8:0] d, output int at);
    @(negedge clk_i);
    while (tx_busy_o) @(negedge clk_i);
    at = cyc;
    exp_q.push_back({1'b0, mask_len(d, len_i)});
    tx_data_i  = d;
    tx_start_i = 1;
    @(negedge clk_i);
    tx_start_i = 0;
  endtask

  task automatic rx_send(logic [8:0] d, int nb, bit stop, int p, bit push);
    if (push) exp_q.push_back({!stop, d & ((9'h1 << nb) - 9'h1)});
    rx_drv = 0;
    repeat (p) @(negedge clk_i);
    for (int i = 0; i < nb; i++) begin
      rx_drv = d[i];
      repeat (p) @(negedge clk_i);
    end
    rx_drv = stop;
    repeat (p) @(negedge clk_i);
    rx_drv = 1;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (8) @(negedge clk_i);
    chk(exp_q.size() == 0, "R8 all expected frames seen", exp_q.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    int t0, t1, p, lows, base;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk(tx_o == 1, "R1 tx_o", tx_o, 1);
    chk(tx_busy_o == 0, "R1 busy", tx_busy_o, 0);
    chk(tx_irq_o == 0 && rx_irq_o == 0, "R1 irqs", {tx_irq_o, rx_irq_o}, 0);
    chk(rx_ready_o == 0, "R1 ready", rx_ready_o, 0);
    chk(rx_frame_err_o == 0 && rx_overrun_o == 0, "R1 err flags",
        {rx_frame_err_o, rx_overrun_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R6 loopback frame and transmit flag
    cur_req = "R3 8-bit loopback";
    tx_send(9'h0A5, t0);
    drain();
    chk(tx_irq_o == 1, "R6 tx irq set", tx_irq_o, 1);
    repeat (5) @(negedge clk_i);
    chk(tx_irq_o == 1, "R6 tx irq held", tx_irq_o, 1);
    tx_irq_clr_i = 1; @(negedge clk_i); tx_irq_clr_i = 0;
    chk(tx_irq_o == 0, "R6 tx irq cleared", tx_irq_o, 0);

    // R2 start bit length, fast then slow
    for (int m = 0; m < 2; m++) begin
      fast_i   = (m == 0);
      reload_i = (m == 0) ? 8'd3 : 8'd2;
      p = bit_ticks(reload_i, fast_i);
      tx_send(9'h0FF, t0);
      lows = 1;
      while (tx_o == 0 && lows < 10000) begin @(negedge clk_i); if (tx_o == 0) lows++; end
      chk(lows == p, "R2 start bit ticks", lows, p);
      drain();
    end

    // R3 lengths
    fast_i = 1; reload_i = 8'd1; p = bit_ticks(1, 1);
    for (int k = 0; k < 3; k++) begin
      len_i = (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
      cur_req = "R3 length select";
      base = got_n;
      tx_send((k == 0) ? 9'h1FF : (k == 1) ? 9'h1A5 : 9'h15A, t0);
      drain();
      chk(got_n == base + 1, "R3 one frame per strobe", got_n - base, 1);
    end

    // R5 gapless transmit stream
    len_i = 2'b01; cur_req = "R5 stream data";
    tx_send(9'h03C, t0);
    tx_send(9'h0C3, t1);
    chk(t1 - t0 == 10 * p, "R5 strobe spacing", t1 - t0, 10 * p);
    drain();

    // R4 strobe while busy is ignored
    cur_req = "R4 data";
    base = got_n;
    tx_send(9'h066, t0);
    repeat (3 * p) @(negedge clk_i);
    chk(tx_busy_o == 1, "R4 busy mid-frame", tx_busy_o, 1);
    tx_data_i = 9'h099; tx_start_i = 1; @(negedge clk_i); tx_start_i = 0;
    drain();
    repeat (12 * p) @(negedge clk_i);
    chk(got_n == base + 1, "R4 ignored strobe", got_n - base, 1);
    chk(tx_o == 1 && tx_busy_o == 0, "R4 line idle", {tx_o, tx_busy_o}, 2);

    // direct receive
    loop_en = 0; rx_drv = 1;
    repeat (4) @(negedge clk_i);
    cur_req = "R8 direct receive";
    rx_send(9'h05A, 8, 1, p, 1);
    drain();
    // R7 runt start pulse
    base = got_n;
    rx_drv = 0; repeat (p / 4) @(negedge clk_i); rx_drv = 1;
    repeat (12 * p) @(negedge clk_i);
    chk(got_n == base && rx_ready_o == 0, "R7 runt rejected", got_n - base, 0);
    chk(rx_irq_o == 0, "R7 no irq", rx_irq_o, 0);
    // R9 low stop bit
    cur_req = "R9 data";
    rx_send(9'h033, 8, 0, p, 1);
    repeat (2 * p) @(negedge clk_i);
    drain();
    // R11 back-to-back receive
    cur_req = "R11 data";
    base = got_n;
    rx_send(9'h0E1, 8, 1, p, 1);
    rx_send(9'h01E, 8, 1, p, 1);
    drain();
    chk(got_n == base + 2, "R11 two frames", got_n - base, 2);
    chk(rx_frame_err_o == 0, "R9 clean stop", rx_frame_err_o, 0);

    // R10 overrun
    mon_en = 0;
    rx_send(9'h011, 8, 1, p, 0);
    rx_send(9'h022, 8, 1, p, 0);
    repeat (p) @(negedge clk_i);
    chk(rx_ready_o == 1, "R10 ready", rx_ready_o, 1);
    chk(rx_overrun_o == 1, "R10 overrun set", rx_overrun_o, 1);
    chk(rx_data_o == 9'h022, "R10 newest data", rx_data_o, 9'h022);
    man_read = 1; man_clr = 1; @(negedge clk_i); man_read = 0; man_clr = 0;
    chk(rx_overrun_o == 0 && rx_ready_o == 0, "R10 cleared by read",
        {rx_overrun_o, rx_ready_o}, 0);
    chk(rx_irq_o == 0, "R8 irq cleared", rx_irq_o, 0);

    summary();
  end
endmodule